// File: doc/BRIEF.md
# DDR3 Bank State Tracker

This block follows the open/closed condition of each bank of a DDR3 device as a stream of already-decoded commands passes by. A memory controller or a bus protocol monitor feeds it one command per clock (no-op, single-bank precharge, precharge of every bank, activate, read, write, refresh or ZQ calibration) together with the bank number and the address word. From that stream it keeps, for every bank, the row that was last opened, whether a column access would be legal now, and whether a new activate or a read is still held off by write recovery.

Each bank carries a three-bit history word. A precharge or an activate loads it, and every clock in which the bank is not the target of a command it shifts by one place. This makes the history fill after two idle ticks, so a newly opened bank becomes ready for reads and writes two no-op cycles after its activate. A separate down-counter per bank starts on a write and blocks activate and read to that bank until it runs out. When a command breaks one of these rules, a one-cycle error pulse reports the bank and a code naming the rule. The command still updates the bank state, so tracking continues after a fault.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset every bank has history 000 and open row 0. No bank is column-ready (col_ready 0) and none is blocked (act_blocked 0). err_pulse, err_bank and err_code are all 0.
- R2: Precharge (cmd_in 1) loads history 110 into the addressed bank, and every other bank takes a no-op tick. If addr_in bit 6 is set, every bank loads 110. Precharging an already closed bank never raises an error.
- R3: Precharge-all (cmd_in 2) loads history 110 into every bank, whatever the bank and address inputs hold.
- R4: Activate (cmd_in 3) loads history 001 into the addressed bank and latches addr_in[14:0] as its open row. Every other bank takes a no-op tick. open_row holds bank b at bits [15*b+14 : 15*b].
- R5: A no-op tick shifts the 3-bit history left by one and copies the new bit 1 into bit 0. Every bank takes this tick on no-op (cmd_in 0), and so does every bank not addressed by a precharge, activate, read or write. col_ready of a bank is high exactly when its history is 111, which is two ticks after an activate.
- R6: Refresh (cmd_in 6) and ZQ calibration (cmd_in 7) leave the history of every bank unchanged.
- R7: A read (cmd_in 4) or write (cmd_in 5) to a bank whose history is not 111 is flagged with code 1. The target's history is left unchanged and the other banks tick.
- R8: A write loads the bank's recovery counter. act_blocked of that bank is high for the 10 cycles that follow the write and low from the 11th onward. A later write restarts the count.
- R9: An activate or read to a bank with act_blocked high is flagged with code 2. For a read that also breaks R7, code 1 is reported instead. The command still takes effect.
- R10: ZQ calibration while any bank's history is not 000 is flagged with code 3, and err_bank gives the lowest-numbered such bank.
- R11: err_pulse is high for exactly the cycle after the offending command's clock edge, together with err_bank and err_code. In every other cycle all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 3 | Decoded command: 0 no-op, 1 precharge, 2 precharge all, 3 activate, 4 read, 5 write, 6 refresh, 7 ZQ |
| bank_in | input | 3 | Target bank |
| addr_in | input | 16 | Address word (row for activate, bit 6 widens precharge) |
| open_row | output | 120 | Open row of every bank, 15 bits per bank |
| col_ready | output | 8 | Per-bank: read/write legal now |
| act_blocked | output | 8 | Per-bank: write recovery still running |
| err_pulse | output | 1 | One-cycle violation strobe |
| err_bank | output | 3 | Bank of the reported violation |
| err_code | output | 2 | 1 not open, 2 write recovery, 3 ZQ with bank not idle |

## Verification
The assertions check on every cycle the effects that follow directly from a single command: an activate capturing its row, a write raising act_blocked, precharge and precharge-all clearing readiness, refresh holding readiness steady, a write to a bank that is not ready producing code 1, and the error fields staying at zero outside a pulse. Some behaviour depends on several commands in a row: the two-tick fill of the history, the exact ten-cycle length of the recovery window, the choice between codes 1 and 2 on a read, and the lowest-bank choice on ZQ. These are shown only by the bench's scenarios, and by its reference model compared on every clock through directed and random command streams.

// File: rtl/ddr_bank_pkg.sv
package ddr_bank_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PRE  = 3'd1,
        CMD_PREA = 3'd2,
        CMD_ACT  = 3'd3,
        CMD_RD   = 3'd4,
        CMD_WR   = 3'd5,
        CMD_REF  = 3'd6,
        CMD_ZQ   = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_NOT_OPEN  = 2'd1,
        ERR_WR_RECOV  = 2'd2,
        ERR_ZQ_BUSY   = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_TICK = 3'd1,
        OP_PRE  = 3'd2,
        OP_ACT  = 3'd3,
        OP_RD   = 3'd4,
        OP_WR   = 3'd5,
        OP_ZQ   = 3'd6
    } bank_op_e;

    localparam int HIST_W      = 3;
    localparam int PRE_ALL_BIT = 6;

    localparam logic [HIST_W-1:0] HIST_PRE   = 3'b110;
    localparam logic [HIST_W-1:0] HIST_ACT   = 3'b001;
    localparam logic [HIST_W-1:0] HIST_READY = 3'b111;
    localparam logic [HIST_W-1:0] HIST_IDLE  = 3'b000;

endpackage

// File: rtl/ddr_bank_cmd_decode.sv
module ddr_bank_cmd_decode
    import ddr_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [2:0]        cmd_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [ADDR_W-1:0] addr_in,
    output bank_op_e          ops [NUM_BANKS]
);

    cmd_e cmd;
    assign cmd = cmd_e'(cmd_in);

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            logic hit;
            hit = (bank_in == BANK_W'(b));
            case (cmd)
                CMD_NOP:  ops[b] = OP_TICK;
                CMD_PRE:  ops[b] = (addr_in[PRE_ALL_BIT] || hit) ? OP_PRE : OP_TICK;
                CMD_PREA: ops[b] = OP_PRE;
                CMD_ACT:  ops[b] = hit ? OP_ACT : OP_TICK;
                CMD_RD:   ops[b] = hit ? OP_RD  : OP_TICK;
                CMD_WR:   ops[b] = hit ? OP_WR  : OP_TICK;
                CMD_REF:  ops[b] = OP_HOLD;
                CMD_ZQ:   ops[b] = OP_ZQ;
                default:  ops[b] = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_slice.sv
module ddr_bank_slice
    import ddr_bank_pkg::*;
#(
    parameter int ROW_W       = 15,
    parameter int WR_RECOVERY = 11,
    localparam int CNT_W      = $clog2(WR_RECOVERY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_op_e         op,
    input  logic [ROW_W-1:0] row_in,
    output logic [ROW_W-1:0] row_q,
    output logic             ready,
    output logic             blocked,
    output err_e             viol
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_RECOVERY - 1);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [ROW_W-1:0]  row;
        logic [CNT_W-1:0]  cnt;
    } slice_t;

    slice_t s_d, s_q;
    err_e   viol_d;

    function automatic logic [HIST_W-1:0] tick_hist(input logic [HIST_W-1:0] h);
        logic [HIST_W-1:0] sh;
        sh    = {h[HIST_W-2:0], 1'b0};
        sh[0] = sh[1];
        return sh;
    endfunction

    always_comb begin
        s_d    = s_q;
        viol_d = ERR_NONE;
        s_d.cnt = (s_q.cnt != '0) ? s_q.cnt - CNT_W'(1) : '0;
        case (op)
            OP_TICK: s_d.hist = tick_hist(s_q.hist);
            OP_PRE:  s_d.hist = HIST_PRE;
            OP_ACT: begin
                if (s_q.cnt != '0) viol_d = ERR_WR_RECOV;
                s_d.hist = HIST_ACT;
                s_d.row  = row_in;
            end
            OP_RD: begin
                if (s_q.hist != HIST_READY) viol_d = ERR_NOT_OPEN;
                else if (s_q.cnt != '0)     viol_d = ERR_WR_RECOV;
            end
            OP_WR: begin
                if (s_q.hist != HIST_READY) viol_d = ERR_NOT_OPEN;
                s_d.cnt = CNT_LOAD;
            end
            OP_ZQ: begin
                if (s_q.hist != HIST_IDLE) viol_d = ERR_ZQ_BUSY;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign row_q   = s_q.row;
    assign ready   = (s_q.hist == HIST_READY);
    assign blocked = (s_q.cnt != '0);
    assign viol    = viol_d;

endmodule

// File: rtl/ddr_bank_err_sel.sv
module ddr_bank_err_sel
    import ddr_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  err_e              viol [NUM_BANKS],
    output logic              err_pulse,
    output logic [BANK_W-1:0] err_bank,
    output logic [1:0]        err_code
);

    typedef struct packed {
        logic              pulse;
        logic [BANK_W-1:0] bank;
        err_e              code;
    } report_t;

    report_t r_d, r_q;

    always_comb begin
        r_d = '{pulse: 1'b0, bank: '0, code: ERR_NONE};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!r_d.pulse && viol[b] != ERR_NONE) begin
                r_d.pulse = 1'b1;
                r_d.bank  = BANK_W'(b);
                r_d.code  = viol[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{pulse: 1'b0, bank: '0, code: ERR_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign err_pulse = r_q.pulse;
    assign err_bank  = r_q.bank;
    assign err_code  = r_q.code;

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_bank_pkg::*;
#(
    parameter int NUM_BANKS   = 8,
    parameter int ADDR_W      = 16,
    parameter int ROW_W       = 15,
    parameter int WR_RECOVERY = 11,
    localparam int BANK_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 cmd_in,
    input  logic [BANK_W-1:0]          bank_in,
    input  logic [ADDR_W-1:0]          addr_in,
    output logic [NUM_BANKS*ROW_W-1:0] open_row,
    output logic [NUM_BANKS-1:0]       col_ready,
    output logic [NUM_BANKS-1:0]       act_blocked,
    output logic                       err_pulse,
    output logic [BANK_W-1:0]          err_bank,
    output logic [1:0]                 err_code
);

    bank_op_e ops  [NUM_BANKS];
    err_e     viol [NUM_BANKS];

    ddr_bank_cmd_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .cmd_in  (cmd_in),
        .bank_in (bank_in),
        .addr_in (addr_in),
        .ops     (ops)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr_bank_slice #(
            .ROW_W       (ROW_W),
            .WR_RECOVERY (WR_RECOVERY)
        ) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (ops[b]),
            .row_in  (addr_in[ROW_W-1:0]),
            .row_q   (open_row[b*ROW_W +: ROW_W]),
            .ready   (col_ready[b]),
            .blocked (act_blocked[b]),
            .viol    (viol[b])
        );
    end

    ddr_bank_err_sel #(
        .NUM_BANKS (NUM_BANKS)
    ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .viol      (viol),
        .err_pulse (err_pulse),
        .err_bank  (err_bank),
        .err_code  (err_code)
    );

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk
    import ddr_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 16,
    parameter int ROW_W     = 15,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 cmd_in,
    input logic [BANK_W-1:0]          bank_in,
    input logic [ADDR_W-1:0]          addr_in,
    input logic [NUM_BANKS*ROW_W-1:0] open_row,
    input logic [NUM_BANKS-1:0]       col_ready,
    input logic [NUM_BANKS-1:0]       act_blocked,
    input logic                       err_pulse,
    input logic [BANK_W-1:0]          err_bank,
    input logic [1:0]                 err_code
);

    AST_PRE_CLOSES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_PRE) |=> (!col_ready[$past(bank_in)] && !err_pulse)); // R2

    AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_PREA) |=> (col_ready == '0)); // R3

    AST_ACT_LATCHES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_ACT) |=> (open_row[$past(bank_in)*ROW_W +: ROW_W] == $past(addr_in[ROW_W-1:0]))); // R4

    AST_REF_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_REF) |=> $stable(col_ready)); // R6

    AST_WR_NOT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_WR && !col_ready[bank_in]) |=>
        (err_pulse && err_code == ERR_NOT_OPEN && err_bank == $past(bank_in))); // R7

    AST_WR_BLOCKS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_WR) |=> act_blocked[$past(bank_in)]); // R8

    AST_NOP_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_in == CMD_NOP) |=> !err_pulse); // R11

    AST_QUIET_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !err_pulse |-> (err_code == ERR_NONE && err_bank == '0)); // R11

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .ROW_W     (ROW_W)
) u_chk (.*);

// File: tb/ddr_bank_tracker_bench.sv
module ddr_bank_tracker_bench;

    localparam int NB    = 8;
    localparam int RW    = 15;
    localparam int AW    = 16;
    localparam int CLK_P = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd_in = 3'd0;
    logic [2:0]        bank_in = 3'd0;
    logic [AW-1:0]     addr_in = '0;
    logic [NB*RW-1:0]  open_row;
    logic [NB-1:0]     col_ready;
    logic [NB-1:0]     act_blocked;
    logic              err_pulse;
    logic [2:0]        err_bank;
    logic [1:0]        err_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int m_hist [NB];
    int m_row  [NB];
    int m_cnt  [NB];
    int e_pulse, e_bank, e_code;

    always #(CLK_P/2) clk = ~clk;

    ddr_bank_tracker u_ddr_bank_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .bank_in(bank_in),
        .addr_in(addr_in), .open_row(open_row), .col_ready(col_ready),
        .act_blocked(act_blocked), .err_pulse(err_pulse),
        .err_bank(err_bank), .err_code(err_code)
    );

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int tick(input int h);
        int s;
        s = (h * 2) % 8;
        if ((s / 2) % 2 == 1) s = s + ((s % 2 == 0) ? 1 : 0);
        else if (s % 2 == 1) s = s - 1;
        return s;
    endfunction

    task automatic compare_all(input string tag);
        logic [NB*RW-1:0] rows;
        logic [NB-1:0]    rdy, blk;
        for (int i = 0; i < NB; i++) begin
            rows[i*RW +: RW] = RW'(m_row[i]);
            rdy[i] = (m_hist[i] == 7);
            blk[i] = (m_cnt[i] != 0);
        end
        check(tag, "col_ready",   128'(col_ready),   128'(rdy));
        check(tag, "act_blocked", 128'(act_blocked), 128'(blk));
        check(tag, "open_row",    128'(open_row),    128'(rows));
        check(tag, "err", 128'({err_pulse, err_bank, err_code}),
              128'({e_pulse[0], e_bank[2:0], e_code[1:0]}));
    endtask

    // Apply one command at a falling edge, update the model, compare after the next rising edge
    task automatic step(input int c, input int b, input int a, input string tag);
        e_pulse = 0; e_bank = 0; e_code = 0;
        case (c)
            3: if (m_cnt[b] != 0) e_code = 2;
            4: if (m_hist[b] != 7) e_code = 1; else if (m_cnt[b] != 0) e_code = 2;
            5: if (m_hist[b] != 7) e_code = 1;
            7: for (int i = NB - 1; i >= 0; i--)
                   if (m_hist[i] != 0) begin e_code = 3; e_bank = i; end
            default: ;
        endcase
        if (e_code != 0) begin
            e_pulse = 1;
            if (c != 7) e_bank = b;
        end
        for (int i = 0; i < NB; i++) begin
            bit hit;
            hit = (i == b);
            if (m_cnt[i] > 0) m_cnt[i]--;
            case (c)
                0: m_hist[i] = tick(m_hist[i]);
                1: m_hist[i] = (hit || ((a >> 6) % 2 == 1)) ? 6 : tick(m_hist[i]);
                2: m_hist[i] = 6;
                3: if (hit) begin m_hist[i] = 1; m_row[i] = a % 32768; end
                   else m_hist[i] = tick(m_hist[i]);
                4: if (!hit) m_hist[i] = tick(m_hist[i]);
                5: if (hit) m_cnt[i] = 10; else m_hist[i] = tick(m_hist[i]);
                default: ;
            endcase
        end
        cmd_in  = 3'(c);
        bank_in = 3'(b);
        addr_in = AW'(a);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic nops(input int n, input string tag);
        for (int k = 0; k < n; k++) step(0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin m_hist[i] = 0; m_row[i] = 0; m_cnt[i] = 0; end
        e_pulse = 0; e_bank = 0; e_code = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");

        // R4 / R5: open a row, ready after two ticks
        step(3, 2, 16'h1234, "R4");
        check("R5", "not ready after act", 128'(col_ready[2]), 128'(0));
        step(0, 0, 0, "R5");
        check("R5", "not ready after one tick", 128'(col_ready[2]), 128'(0));
        step(0, 0, 0, "R5");
        check("R5", "ready after two ticks", 128'(col_ready[2]), 128'(1));

        // R7: read to open bank fine, read/write to closed bank flagged
        step(4, 2, 0, "R7");
        step(4, 3, 0, "R7");
        check("R7", "code not open", 128'(err_code), 128'(1));
        step(5, 6, 0, "R7");
        nops(1, "R11");

        // R8 / R9: write recovery window
        step(5, 2, 0, "R8");
        nops(3, "R8");
        step(4, 2, 0, "R9");
        check("R9", "read in recovery", 128'(err_code), 128'(2));
        nops(5, "R8");
        check("R8", "still blocked 10th cycle", 128'(act_blocked[2]), 128'(1));
        nops(1, "R8");
        check("R8", "released 11th cycle", 128'(act_blocked[2]), 128'(0));
        step(5, 2, 0, "R8");
        step(3, 2, 16'h0777, "R9");
        check("R9", "act in recovery", 128'(err_code), 128'(2));
        step(4, 2, 0, "R9");
        check("R9", "not-open beats recovery", 128'(err_code), 128'(1));
        nops(12, "R8");

        // R2 / R3: precharge variants
        step(3, 4, 16'h7abc, "R4");
        step(3, 5, 16'h0101, "R4");
        nops(2, "R5");
        step(1, 4, 0, "R2");
        step(1, 4, 0, "R2");
        check("R2", "re-precharge not flagged", 128'(err_pulse), 128'(0));
        step(1, 0, 16'h0040, "R2");
        check("R2", "bit6 closes all", 128'(col_ready), 128'(0));
        step(3, 1, 16'h2222, "R4");
        step(3, 7, 16'hffff, "R4");
        nops(2, "R5");
        step(2, 3, 0, "R3");
        check("R3", "precharge all", 128'(col_ready), 128'(0));
        nops(2, "R5");

        // R6: refresh and ZQ hold history
        step(3, 5, 16'h0033, "R4");
        step(0, 0, 0, "R6");
        step(6, 0, 0, "R6");
        step(6, 0, 0, "R6");
        check("R6", "refresh holds", 128'(col_ready[5]), 128'(0));
        step(0, 0, 0, "R6");
        check("R6", "fills after refresh", 128'(col_ready[5]), 128'(1));

        // R10: ZQ with a bank not idle
        step(3, 6, 16'h0010, "R4");
        step(7, 0, 0, "R10");
        check("R10", "lowest busy bank", 128'({err_bank, err_code}), 128'({3'd5, 2'd3}));
        step(2, 0, 0, "R3");
        nops(2, "R5");
        step(7, 0, 0, "R10");
        check("R10", "idle ZQ ok", 128'(err_pulse), 128'(0));

        // Random command stream against the model
        for (int k = 0; k < 600; k++) begin
            int c;
            c = $urandom_range(0, 7);
            if (c == 7 && $urandom_range(0, 3) != 0) c = 0;
            step(c, $urandom_range(0, 7), $urandom_range(0, 65535), "R11");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule